// File: doc/BRIEF.md
# Key-Gated Control Register Bank

This block is a byte-wide register bank on a small synchronous bus. The bus has an address, write data, a write strobe and a combinational read-data return. The bank holds three read-only identification bytes, a free scratch byte and a two-byte key. It also holds a command register whose bits fire one-cycle strobes, and a device control register with a loopback select and a spare bit.

Writes to the upper part of the address space are guarded by the key. A write at or above the command address changes state only when both key bytes hold the magic pair. Any other write there is dropped without an error. The scratch and key bytes can be written at any time.

A command bit can request a software reset. This reset is registered and lasts one cycle. It returns every register to the state that the hard reset pin gives, so the bank comes out of either kind of reset locked again.

Top module: `ctl_bank`

## Requirements
- R1: Addresses 0x00, 0x01 and 0x02 always read 0x01, 0x01 and 0xA0 in that order. Writes to them have no effect.
- R2: Address 0x03 is a read/write scratch byte that resets to 0x00. A write to it takes effect whether the bank is locked or unlocked.
- R3: Address 0x04 (key high) and address 0x05 (key low) are read/write bytes that reset to 0x00. A write to either takes effect in any lock state.
- R4: A write to any address from 0x06 to 0x7F is discarded unless key high holds 0xA0 and key low holds 0x01 when the write is sampled. Either byte alone being correct does not unlock the bank.
- R5: An unlocked write to 0x06 with bit 0 set drives `align_o` high for exactly the one cycle that follows the write edge. A locked write, or a write with bit 0 clear, gives no strobe.
- R6: An unlocked write to 0x06 with bit 1 set drives `soft_rst_o` high for the one cycle after the write edge. At the next edge, the scratch byte, both key bytes and the device register return to 0x00, which leaves the bank locked.
- R7: Address 0x06 always reads 0x00.
- R8: At address 0x08, bit 0 is the loopback select (1 = loop transmit to receive) and drives `loopback_o`. Bit 1 is a read/write spare bit. Both reset to 0. Bits 7:2 read 0 and cannot be written.
- R9: Every address not listed above reads 0x00.
- R10: After the hard reset pin is released, every register holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous assert |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_data | output | 8 | Read data for `addr`, combinational |
| align_o | output | 1 | One-cycle FIFO-alignment command strobe |
| soft_rst_o | output | 1 | One-cycle software global reset strobe |
| loopback_o | output | 1 | Loopback select from the device register |

## Verification
The bench builds the bank with its default parameters: a 7-bit address, 8-bit data, key pair 0xA0/0x01 and a two-stage reset synchronizer. With a 7-bit address the whole space of 128 locations can be swept after reset, so every unimplemented location is read. Random traffic places the magic key bytes often enough that the bank moves in and out of the unlocked state many times. Command writes in that traffic fire strobes and software resets in the middle of the sequence.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;
  localparam int unsigned BUS_AW = 7;
  localparam int unsigned BUS_DW = 8;
  localparam int unsigned DEV_W  = 2;

  localparam logic [BUS_AW-1:0] A_REV   = 7'h00;
  localparam logic [BUS_AW-1:0] A_ID_LO = 7'h01;
  localparam logic [BUS_AW-1:0] A_ID_HI = 7'h02;
  localparam logic [BUS_AW-1:0] A_SCR   = 7'h03;
  localparam logic [BUS_AW-1:0] A_KEY_H = 7'h04;
  localparam logic [BUS_AW-1:0] A_KEY_L = 7'h05;
  localparam logic [BUS_AW-1:0] A_CMD   = 7'h06;
  localparam logic [BUS_AW-1:0] A_DEV   = 7'h08;
  // first address guarded by the key
  localparam logic [BUS_AW-1:0] A_GUARD = 7'h06;

  localparam int unsigned CMD_ALIGN = 0;
  localparam int unsigned CMD_SRST  = 1;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ctl_key_lock.sv
module ctl_key_lock #(
  parameter int unsigned     DW     = 8,
  parameter logic [DW-1:0]   KEY_HI = 8'hA0,
  parameter logic [DW-1:0]   KEY_LO = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_hi,
  output logic [DW-1:0] key_lo,
  output logic          unlocked
);
  logic [DW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic          en;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (soft_clr) begin
      hi_d = '0;
      lo_d = '0;
    end else begin
      if (wr_hi) hi_d = wdata;
      if (wr_lo) lo_d = wdata;
    end
  end

  assign en = soft_clr | wr_hi | wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign key_hi   = hi_q;
  assign key_lo   = lo_q;
  assign unlocked = (hi_q == KEY_HI) && (lo_q == KEY_LO);

  // R6
  relock_after_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (hi_q == '0) && (lo_q == '0));
endmodule

// File: rtl/ctl_cmd_pulse.sv
module ctl_cmd_pulse (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_bits,
  output logic       align_q,
  output logic       srst_q
);
  import ctl_bank_pkg::*;

  logic align_d, srst_d;

  always_comb begin
    align_d = cmd_wr & cmd_bits[CMD_ALIGN];
    srst_d  = cmd_wr & cmd_bits[CMD_SRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      align_q <= align_d;
      srst_q  <= srst_d;
    end
  end

  // R5
  align_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_q |-> $past(cmd_wr && cmd_bits[CMD_ALIGN]));

  // R6
  srst_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> $past(cmd_wr && cmd_bits[CMD_SRST]));
endmodule

// File: rtl/ctl_dev_reg.sv
module ctl_dev_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dev_q
);
  logic [W-1:0] dev_d;
  logic         en;

  always_comb begin
    dev_d = soft_clr ? '0 : wdata;
  end

  assign en = soft_clr | wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dev_q <= '0;
    else if (en) dev_q <= dev_d;
  end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank #(
  parameter int unsigned         AW       = ctl_bank_pkg::BUS_AW,
  parameter int unsigned         DW       = ctl_bank_pkg::BUS_DW,
  parameter int unsigned         SYNC_LEN = 2,
  parameter logic [DW-1:0]       REV_VAL  = 8'h01,
  parameter logic [DW-1:0]       ID_LO    = 8'h01,
  parameter logic [DW-1:0]       ID_HI    = 8'hA0,
  parameter logic [DW-1:0]       KEY_HI   = 8'hA0,
  parameter logic [DW-1:0]       KEY_LO   = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  output logic [DW-1:0] rd_data,
  output logic          align_o,
  output logic          soft_rst_o,
  output logic          loopback_o
);
  import ctl_bank_pkg::*;

  localparam int unsigned DVW = DEV_W;

  logic            rst_sync_n;
  logic            srst_q, align_q, unlocked;
  logic            wr_ok, guard_ok;
  logic            wr_scr, wr_hi, wr_lo, wr_cmd, wr_dev;
  logic [DW-1:0]   key_hi, key_lo;
  logic [DW-1:0]   scr_q, scr_d;
  logic            scr_en;
  logic [DVW-1:0]  dev_q;

  ctl_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // bus decode: the soft-reset cycle swallows writes
  assign wr_ok    = wr_en & ~srst_q;
  assign guard_ok = (addr >= AW'(A_GUARD)) ? unlocked : 1'b1;
  assign wr_scr   = wr_ok && (addr == AW'(A_SCR));
  assign wr_hi    = wr_ok && (addr == AW'(A_KEY_H));
  assign wr_lo    = wr_ok && (addr == AW'(A_KEY_L));
  assign wr_cmd   = wr_ok && guard_ok && (addr == AW'(A_CMD));
  assign wr_dev   = wr_ok && guard_ok && (addr == AW'(A_DEV));

  ctl_key_lock #(.DW(DW), .KEY_HI(KEY_HI), .KEY_LO(KEY_LO)) u_key (
    .clk(clk), .rst_n(rst_sync_n), .soft_clr(srst_q),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata),
    .key_hi(key_hi), .key_lo(key_lo), .unlocked(unlocked)
  );

  ctl_cmd_pulse u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(wr_cmd), .cmd_bits(wdata[1:0]),
    .align_q(align_q), .srst_q(srst_q)
  );

  ctl_dev_reg #(.W(DVW)) u_dev (
    .clk(clk), .rst_n(rst_sync_n), .soft_clr(srst_q),
    .wr(wr_dev), .wdata(wdata[DVW-1:0]), .dev_q(dev_q)
  );

  // scratch byte
  always_comb begin
    scr_d = srst_q ? '0 : wdata;
  end
  assign scr_en = srst_q | wr_scr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  scr_q <= '0;
    else if (scr_en)  scr_q <= scr_d;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if      (addr == AW'(A_REV))   rd_data = REV_VAL;
    else if (addr == AW'(A_ID_LO)) rd_data = ID_LO;
    else if (addr == AW'(A_ID_HI)) rd_data = ID_HI;
    else if (addr == AW'(A_SCR))   rd_data = scr_q;
    else if (addr == AW'(A_KEY_H)) rd_data = key_hi;
    else if (addr == AW'(A_KEY_L)) rd_data = key_lo;
    else if (addr == AW'(A_DEV))   rd_data = DW'(dev_q);
  end

  assign align_o    = align_q;
  assign soft_rst_o = srst_q;
  assign loopback_o = dev_q[0];

  // R2
  scratch_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !srst_q && addr == AW'(A_SCR)) |=> (scr_q == $past(wdata)));

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !srst_q && !unlocked && addr == AW'(A_DEV)) |=> $stable(dev_q));

  // R6
  soft_clears_dev_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srst_q |=> (dev_q == '0) && (scr_q == '0));
endmodule

// File: tb/test_ctl_bank.sv
`timescale 1ns/1ps
module test_ctl_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic [7:0] rd_data;
  logic       align_o, soft_rst_o, loopback_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] m_scr, m_kh, m_kl;
  logic [1:0] m_dev;

  always #10 clk = ~clk;

  ctl_bank i_ctl_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_data(rd_data), .align_o(align_o), .soft_rst_o(soft_rst_o),
    .loopback_o(loopback_o)
  );

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    case (a)
      7'h00: exp_rd = 8'h01;
      7'h01: exp_rd = 8'h01;
      7'h02: exp_rd = 8'hA0;
      7'h03: exp_rd = m_scr;
      7'h04: exp_rd = m_kh;
      7'h05: exp_rd = m_kl;
      7'h08: exp_rd = {6'b0, m_dev};
      default: exp_rd = 8'h00;
    endcase
  endfunction

  function automatic bit model_unlocked();
    return (m_kh == 8'hA0) && (m_kl == 8'h01);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_scr = 8'h00; m_kh = 8'h00; m_kl = 8'h00; m_dev = 2'b00;
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a;
    #1;
    e = exp_rd(a);
    chk(rd_data == e, req, rd_data, e);
  endtask

  // write, then check the strobes in the two cycles that follow
  task automatic wr_chk(input logic [6:0] a, input logic [7:0] d);
    bit unl, e_al, e_sr;
    unl  = model_unlocked();
    e_al = 1'b0;
    e_sr = 1'b0;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      7'h03: m_scr = d;
      7'h04: m_kh  = d;
      7'h05: m_kl  = d;
      7'h06: if (unl) begin e_al = d[0]; e_sr = d[1]; end
      7'h08: if (unl) m_dev = d[1:0];
      default: ;
    endcase
    chk(align_o == e_al, "R5 align strobe", align_o, e_al);
    chk(soft_rst_o == e_sr, "R6 soft strobe", soft_rst_o, e_sr);
    @(negedge clk);
    if (e_sr) model_clear();
    chk(align_o == 1'b0, "R5 align one cycle", align_o, 0);
    chk(soft_rst_o == 1'b0, "R6 soft one cycle", soft_rst_o, 0);
    chk(loopback_o == m_dev[0], "R8 loopback pin", loopback_o, m_dev[0]);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h1234_5678);
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0;
    model_clear();
    hard_reset();

    // R10 R1 R3 R7 R9: reset sweep of the full address space
    for (int a = 0; a < 128; a++) rd_chk(7'(a), "R10 reset sweep");
    chk(loopback_o == 1'b0, "R10 loopback reset", loopback_o, 0);

    // R1: fixed bytes ignore writes
    for (int a = 0; a < 3; a++) begin
      wr_chk(7'(a), 8'hFF);
      rd_chk(7'(a), "R1 fixed id");
    end

    // R2: scratch writable while locked
    wr_chk(7'h03, 8'h5A); rd_chk(7'h03, "R2 scratch locked");

    // R4: locked, half key high, half key low
    wr_chk(7'h08, 8'h03); rd_chk(7'h08, "R4 locked drop");
    wr_chk(7'h04, 8'hA0); rd_chk(7'h04, "R3 key hi");
    wr_chk(7'h08, 8'h03); rd_chk(7'h08, "R4 half key hi");
    wr_chk(7'h04, 8'h00); wr_chk(7'h05, 8'h01); rd_chk(7'h05, "R3 key lo");
    wr_chk(7'h08, 8'h03); rd_chk(7'h08, "R4 half key lo");
    wr_chk(7'h07, 8'h55); rd_chk(7'h07, "R9 unimpl");

    // R8: full key unlocks device register
    wr_chk(7'h04, 8'hA0);
    wr_chk(7'h08, 8'hFF); rd_chk(7'h08, "R8 dev upper bits");
    wr_chk(7'h08, 8'h02); rd_chk(7'h08, "R8 spare bit");
    wr_chk(7'h08, 8'h01); rd_chk(7'h08, "R8 loopback bit");
    wr_chk(7'h7F, 8'hFF); rd_chk(7'h7F, "R9 top address");

    // R5 R7: align strobe and pulse register readback
    wr_chk(7'h06, 8'h01); rd_chk(7'h06, "R7 cmd reads zero");
    wr_chk(7'h05, 8'h00);
    wr_chk(7'h06, 8'h01);   // locked: no strobe (R5)
    wr_chk(7'h05, 8'h01);

    // R6: soft reset relocks and clears everything
    wr_chk(7'h03, 8'h77);
    wr_chk(7'h06, 8'h03);
    rd_chk(7'h03, "R6 scratch cleared");
    rd_chk(7'h04, "R6 key hi cleared");
    rd_chk(7'h05, "R6 key lo cleared");
    rd_chk(7'h08, "R6 dev cleared");
    wr_chk(7'h08, 8'h01); rd_chk(7'h08, "R6 relocked");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [6:0] a;
      logic [7:0] d;
      r = $urandom % 16;
      a = (r < 10) ? 7'(r) : 7'($urandom % 128);
      d = 8'($urandom);
      if (a == 7'h04 && ($urandom % 2) == 0) d = 8'hA0;
      if (a == 7'h05 && ($urandom % 2) == 0) d = 8'h01;
      if (a == 7'h06) d = (($urandom % 8) == 0) ? (d & 8'h03) : (d & 8'h01);
      if (($urandom % 10) < 6) wr_chk(a, d);
      rd_chk(a, "R4 random readback");
    end

    // R10: hard reset mid-run
    wr_chk(7'h04, 8'hA0); wr_chk(7'h05, 8'h01);
    wr_chk(7'h03, 8'h33); wr_chk(7'h08, 8'h03);
    hard_reset();
    for (int a = 0; a < 10; a++) rd_chk(7'(a), "R10 hard reset");
    chk(loopback_o == 1'b0, "R10 loopback after reset", loopback_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule